// File: doc/BRIEF.md
# ARINC 429 Receive Bit-Timing Validator

This block sits behind the line receiver of a bipolar return-to-zero serial input. It is fed three comparator levels (ONE, ZERO and NULL) and samples them on a 1 MHz reference clock. It qualifies each data pulse by its width and checks its spacing from the previous bit. For every accepted bit it emits a one-clock strobe together with the bit value. A timing violation raises a one-clock error pulse and discards the word in progress.

Before each word may start, the line must show a proper inter-word null gap. A counter gates the start of every reception on that gap. A speed-select input slows the effective sample rate by a factor of eight for low-speed links, and all sample counts then apply to the slower sample stream. Word assembly, parity and host access belong to the blocks that consume the strobe.

Top module: `a429_bit_timer`

## Requirements
- R1: After reset, bit_vld_o and err_o are low and the block waits for a word gap; pulses driven before a qualifying gap give no strobe and no error.
- R2: A level counts only after three consecutive matching samples; a ONE lasting two samples and then NULL has no effect (no strobe, no error).
- R3: A ONE or ZERO lasting at least three samples and followed by three consecutive NULL samples is accepted: bit_vld_o pulses and bit_o is 1 for ONE and 0 for ZERO.
- R4: A pending level whose three-sample run reaches the oldest three of the ten samples while the newest three are not all NULL is rejected with err_o and the word is dropped; a pulse of 7 samples is accepted and one of 8 or more is rejected.
- R5: For bits 2 to 32 of a word, the spacing from the previous accepted bit must be 8 to 12 samples inclusive; a spacing of 7 or 13 raises err_o instead of a strobe.
- R6: While a word is in progress, 13 samples passing without an accepted bit raises err_o.
- R7: The first bit of a word has no spacing constraint; it may arrive any time after the gap.
- R8: After the 32nd bit or an error, reception stays off until a gap: every 10 samples the NULL history is checked for NULL in both its newest three and oldest three samples; three hits in a row arm the next word and a miss clears the count. Pulses in this phase give no strobe and no error.
- R9: With low_speed_i = 1 a sample is taken on every eighth clock only, and all sample counts of R2 to R8 apply to those samples.
- R10: bit_vld_o and err_o are single-clock pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 1 MHz reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| low_speed_i | input | 1 | 1 selects the slow link rate (one sample per 8 clocks) |
| one_i | input | 1 | Line comparator reports the ONE level |
| zero_i | input | 1 | Line comparator reports the ZERO level |
| null_i | input | 1 | Line comparator reports the NULL level |
| bit_vld_o | output | 1 | One-clock strobe for an accepted bit |
| bit_o | output | 1 | Value of the accepted bit, valid with bit_vld_o |
| err_o | output | 1 | One-clock pulse on a timing violation |

## Verification
A wrong spacing counter shows up at the accepted or rejected bit itself. One bit time after the faulty count, a strobe appears where an error was due, or the reverse. A stuck gap counter or sequencer state makes a whole word vanish or be accepted without its gap, which the scoreboard sees as missing or extra strobes within one word time. A broken level history corrupts bit_o or the width decision on the very bit that passes through it. In low-speed mode every such effect arrives eight times later in clocks.

// File: rtl/a429_bt_pkg.sv
package a429_bt_pkg;
  typedef enum logic {
    ST_GAP = 1'b0,
    ST_RUN = 1'b1
  } rx_state_e;
endpackage

// File: rtl/a429_bt_tick.sv
module a429_bt_tick #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_speed_i,
  output logic tick_o
);
  localparam int W = $clog2(DIV);
  logic [W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt <= '0;
    else if (!low_speed_i)       cnt <= '0;
    else if (cnt == W'(DIV - 1)) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

  assign tick_o = !low_speed_i || (cnt == W'(DIV - 1));
endmodule

// File: rtl/a429_bt_lvl_sr.sv
module a429_bt_lvl_sr #(
  parameter int LEN = 10,
  parameter int RUN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic smp_i,
  output logic lo_run_o,
  output logic hi_run_o
);
  logic [LEN-1:0] sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr <= '0;
    else if (tick_i) sr <= {sr[LEN-2:0], smp_i};
  end

  // bit 0 newest
  assign lo_run_o = &sr[RUN-1:0];
  assign hi_run_o = &sr[LEN-1:LEN-RUN];
endmodule

// File: rtl/a429_bt_gap.sv
module a429_bt_gap #(
  parameter int PER  = 10,
  parameter int NEED = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic active_i,
  input  logic hit_i,
  output logic armed_o
);
  localparam int PW = $clog2(PER);
  localparam int CW = $clog2(NEED + 1);
  logic [PW-1:0] ph;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph  <= '0;
      cnt <= '0;
    end else if (!active_i) begin
      ph  <= '0;
      cnt <= '0;
    end else if (tick_i) begin
      if (ph == PW'(PER - 1)) begin
        ph <= '0;
        if (!hit_i)                  cnt <= '0;
        else if (cnt != CW'(NEED))   cnt <= cnt + 1'b1;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  assign armed_o = (cnt == CW'(NEED));
endmodule

// File: rtl/a429_bit_timer.sv
module a429_bit_timer
  import a429_bt_pkg::*;
#(
  parameter int SR_LEN    = 10,
  parameter int RUN_LEN   = 3,
  parameter int SPC_MIN   = 8,
  parameter int SPC_MAX   = 12,
  parameter int GAP_PER   = 10,
  parameter int GAP_NEED  = 3,
  parameter int LS_DIV    = 8,
  parameter int WORD_BITS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_speed_i,
  input  logic one_i,
  input  logic zero_i,
  input  logic null_i,
  output logic bit_vld_o,
  output logic bit_o,
  output logic err_o
);
  localparam int SW = $clog2(SPC_MAX + 2);
  localparam int BW = $clog2(WORD_BITS + 1);
  localparam int NL = 3;

  logic          tick;
  logic [NL-1:0] smp, lo_run, hi_run;
  logic          armed;
  rx_state_e     state;
  logic [BW-1:0] bit_cnt;
  logic [SW-1:0] spc;
  logic          pend, pval;
  logic          run_tick, in_word, accept, spc_bad, null_miss, late, fault, good;

  a429_bt_tick #(.DIV(LS_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .low_speed_i(low_speed_i), .tick_o(tick)
  );

  // index 0 ONE, 1 ZERO, 2 NULL
  assign smp = {null_i, zero_i, one_i};

  for (genvar g = 0; g < NL; g++) begin : g_lvl
    a429_bt_lvl_sr #(.LEN(SR_LEN), .RUN(RUN_LEN)) u_sr (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .smp_i(smp[g]),
      .lo_run_o(lo_run[g]), .hi_run_o(hi_run[g])
    );
  end

  a429_bt_gap #(.PER(GAP_PER), .NEED(GAP_NEED)) u_gap (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .active_i(state == ST_GAP), .hit_i(lo_run[2] & hi_run[2]),
    .armed_o(armed)
  );

  always_comb begin
    run_tick  = tick && (state == ST_RUN);
    in_word   = (bit_cnt != '0);
    accept    = run_tick && pend && lo_run[2];
    spc_bad   = in_word && ((spc < SW'(SPC_MIN)) || (spc > SW'(SPC_MAX)));
    // level aged to the top of the window with no trailing null
    null_miss = run_tick && pend && (hi_run[0] || hi_run[1]) && !lo_run[2];
    late      = run_tick && in_word && !accept && (spc > SW'(SPC_MAX));
    fault     = (accept && spc_bad) || null_miss || late;
    good      = accept && !spc_bad;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_GAP;
      bit_cnt   <= '0;
      spc       <= '0;
      pend      <= 1'b0;
      pval      <= 1'b0;
      bit_vld_o <= 1'b0;
      bit_o     <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      bit_vld_o <= good;
      err_o     <= fault;
      if (good) bit_o <= pval;
      if (state == ST_GAP) begin
        pend    <= 1'b0;
        bit_cnt <= '0;
        if (armed) state <= ST_RUN;
      end else if (fault) begin
        state   <= ST_GAP;
        pend    <= 1'b0;
        bit_cnt <= '0;
      end else if (tick) begin
        if (good) begin
          spc  <= SW'(1);
          pend <= 1'b0;
          if (bit_cnt == BW'(WORD_BITS - 1)) begin
            bit_cnt <= '0;
            state   <= ST_GAP;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end else begin
          if (spc <= SW'(SPC_MAX)) spc <= spc + 1'b1;
          if (!pend && (lo_run[0] || lo_run[1])) begin
            pend <= 1'b1;
            pval <= lo_run[0];
          end
        end
      end
    end
  end
endmodule

// File: rtl/a429_bit_timer_chk.sv
module a429_bit_timer_chk
  import a429_bt_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      low_speed_i,
  input logic      tick_i,
  input rx_state_e st_i,
  input logic      bit_vld_i,
  input logic      err_i
);
  p_strobe_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_i |=> !bit_vld_i);

  p_err_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> !err_i);

  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_vld_i && err_i));

  p_strobe_in_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_i |-> ($past(st_i) == ST_RUN));

  p_err_drops_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> (st_i == ST_GAP));

  p_slow_sample_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_speed_i && tick_i) |=> (!tick_i || !low_speed_i));
endmodule

bind a429_bit_timer a429_bit_timer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .low_speed_i(low_speed_i), .tick_i(tick),
  .st_i(state), .bit_vld_i(bit_vld_o), .err_i(err_o)
);

// File: tb/tb_a429_bit_timer.sv
module tb_a429_bit_timer;
  localparam int CLK_PERIOD = 10;
  localparam int LS_DIV     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ls = 1'b0, one = 1'b0, zero = 1'b0, nul = 1'b1;
  logic bit_vld, bit_val, err;

  int vec = 0, fail = 0, exp_err = 0, err_seen = 0;
  logic exp_q[$];
  logic prev_vld = 1'b0;
  logic done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  a429_bit_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .low_speed_i(ls), .one_i(one), .zero_i(zero),
    .null_i(nul), .bit_vld_o(bit_vld), .bit_o(bit_val), .err_o(err)
  );

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    if (bit_vld) begin
      vec++;
      if (exp_q.size() == 0) begin
        fail++;
        $display("FAIL R8: unexpected strobe value=%0b expected none", bit_val);
      end else begin
        logic e;
        e = exp_q.pop_front();
        if (bit_val !== e) begin
          fail++;
          $display("FAIL R3: bit value actual=%0b expected=%0b", bit_val, e);
        end
      end
    end
    if ((bit_vld && err) || (bit_vld && prev_vld)) begin
      fail++;
      $display("FAIL R10: vld=%0b err=%0b prev_vld=%0b expected single pulses",
               bit_vld, err, prev_vld);
    end
    prev_vld = bit_vld;
    if (err) err_seen++;
  end

  task automatic hold(input logic o, input logic z, input logic n, input int t);
    one = o; zero = z; nul = n;
    repeat (t * (ls ? LS_DIV : 1)) @(negedge clk);
  endtask

  task automatic send_bit(input logic v, input int h, input int n, input logic exp);
    if (exp) exp_q.push_back(v);
    hold(v, !v, 1'b0, h);
    hold(1'b0, 1'b0, 1'b1, n);
  endtask

  task automatic send_word(input logic [31:0] w, input int h, input int n);
    for (int i = 0; i < 32; i++) send_bit(w[i], h, n, 1'b1);
  endtask

  task automatic check(input string tag);
    vec++;
    if (err_seen != exp_err || exp_q.size() != 0) begin
      fail++;
      $display("FAIL %s: errors actual=%0d expected=%0d, pending bits=%0d expected 0",
               tag, err_seen, exp_err, exp_q.size());
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    vec++;
    if (bit_vld !== 1'b0 || err !== 1'b0) begin
      fail++;
      $display("FAIL R1: reset vld=%0b err=%0b expected 0 0", bit_vld, err);
    end
    // R1: pulses with no prior gap are ignored
    for (int i = 0; i < 6; i++) send_bit(i[0], 5, 5, 1'b0);
    check("R1");
    hold(0, 0, 1, 80);
    // R3 R7: nominal word, first bit after a long gap
    send_word(32'hA5C3_0F96, 5, 5);
    // R8: pulses straight after the word are ignored
    for (int i = 0; i < 4; i++) send_bit(1'b1, 5, 5, 1'b0);
    check("R8");
    hold(0, 0, 1, 80);
    check("R3");
    // R2: two-sample pulse has no effect, then spacing 8 word (R5 minimum)
    hold(1, 0, 0, 2);
    hold(0, 0, 1, 20);
    check("R2");
    send_word(32'h0123_4567, 3, 5);
    hold(0, 0, 1, 80);
    check("R5");
    // R4 boundary: 7-sample pulses, spacing 12 (R5 maximum)
    send_word(32'hFEDC_BA98, 7, 5);
    hold(0, 0, 1, 80);
    check("R4");
    // R5: spacing 7
    send_bit(1'b1, 3, 4, 1'b1);
    send_bit(1'b0, 3, 4, 1'b0);
    exp_err++;
    hold(0, 0, 1, 80);
    check("R5");
    // R5: spacing 13
    send_bit(1'b0, 5, 8, 1'b1);
    send_bit(1'b1, 5, 8, 1'b0);
    exp_err++;
    hold(0, 0, 1, 80);
    check("R5");
    // R6: line goes quiet mid-word
    send_bit(1'b1, 5, 5, 1'b1);
    send_bit(1'b0, 5, 5, 1'b1);
    exp_err++;
    hold(0, 0, 1, 80);
    check("R6");
    // R4: 8-sample pulse as first bit
    send_bit(1'b1, 8, 80, 1'b0);
    exp_err++;
    check("R4");
    // R4: long pulse, word dropped, next word fine
    send_bit(1'b0, 20, 80, 1'b0);
    exp_err++;
    send_word(32'h5555_AAAA, 5, 5);
    hold(0, 0, 1, 80);
    check("R4");
    // R9: low speed
    ls = 1'b1;
    hold(0, 0, 1, 80);
    send_word(32'h3C3C_9D81, 5, 5);
    hold(0, 0, 1, 80);
    check("R9");
    // R9: spacing rule in slow samples
    send_bit(1'b1, 3, 4, 1'b1);
    send_bit(1'b1, 3, 4, 1'b0);
    exp_err++;
    hold(0, 0, 1, 80);
    check("R9");
    finish_run();
  end
endmodule